// File: doc/BRIEF.md
# Flash Page Lock Access Guard

This block stands between a small microcontroller's flash controller and every agent that wants to read, write or erase program flash. It decides, one request at a time, whether the access may go ahead. Two software-owned control bits gate modification: a write-enable bit and an erase-enable bit. A security byte held in the final byte of user flash gives the number of protected pages from page 0 upward. That byte is captured once, on the first clock after reset is released.

Each request carries an operation, a target address, a flag that marks the debug port as the requester, and the address of the code that issues it. Firmware counts as trusted when its executing address lies in a protected page. The block answers one cycle later with a grant pulse or a violation pulse. A violation pulse comes with a reason code. User flash size is a parameter (8, 4 or 2 KB). The address of the security byte and the index of the page that holds it follow from that size.

Top module: `flash_guard`

## Requirements
- R1: While reset is asserted, and on the first clock after release (when the security byte is captured from `lockByteIn`), `grant`, `violation` and `violCode` stay 0. A request is ignored unless it is presented after that capture edge. `lockByteIn` is ignored after the capture.
- R2: With captured byte B, the count n = 255 - B (bitwise complement). Pages 0 to n-1 are protected. Pages are 512 bytes, so the page is address divided by 512.
- R3: The page holding the security byte is protected exactly when B is not 0xFF. `lockAddr` equals user bytes minus 1 (0x1FFF for 8 KB), and that page is the last page.
- R4: A request from the debug port (`reqDebug`=1), or from firmware executing in an unprotected page, that targets a protected page is denied with `violCode`=3, whatever the operation.
- R5: Firmware executing in a protected page may read any page. Its writes and erases, to any page, depend only on the control bits.
- R6: A firmware write (`reqOp`=01) with the write-enable bit 0 is denied with `violCode`=1.
- R7: A firmware erase (`reqOp`=10) is denied with `violCode`=2 unless both the write-enable and erase-enable bits are 1.
- R8: Debug-port requests are not gated by the control bits.
- R9: When a request fails both the page check and a control-bit check, the code reported is 3.
- R10: The response appears in the cycle after the request and lasts one cycle. `grant` and `violation` are never both 1. `violCode` is 0 when `violation` is 0.
- R11: When `ctlWrEn` is 1, `ctlWrData[0]` loads the write-enable bit and `ctlWrData[1]` loads the erase-enable bit. A request in the following cycle sees the new values. Both bits reset to 0.
- R12: A request with `reqOp`=11 (reserved) gives neither grant nor violation. A read is `reqOp`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockByteIn | input | 8 | Security byte contents, as read from `lockAddr` |
| ctlWrEn | input | 1 | Load strobe for the control bits |
| ctlWrData | input | 2 | {erase-enable, write-enable} |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 00 read, 01 write, 10 erase, 11 reserved |
| reqAddr | input | ADDR_W | Target flash address |
| reqDebug | input | 1 | 1 when the debug port is the requester |
| execAddr | input | ADDR_W | Address of the code issuing a firmware request |
| lockAddr | output | ADDR_W | Address of the security byte |
| grant | output | 1 | Request allowed (one-cycle pulse) |
| violation | output | 1 | Request refused (one-cycle pulse) |
| violCode | output | 2 | 1 write off, 2 erase off, 3 page protected |

## Verification
The bench targets these corner cases:
- A request presented on the capture cycle. A guard that opened too early would grant it.
- Security bytes 0xFF, 0xFE, 0xFB and 0x00. They expose an off-by-one in the page count, a last page that is always or never protected, and a count that overruns the page range.
- Trusted code writing to a protected page, and a debug write with both control bits clear. Each shows whether the protection rules and the control-bit rules were mixed up.
- A request that fails both checks. It shows whether the reason priority is wrong.
- Back-to-back requests, and a control-bit update immediately followed by a request. These catch stretched pulses and a one-cycle lag on the control bits.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_WR_OFF = 2'd1,
    RSN_ER_OFF = 2'd2,
    RSN_LOCKED = 2'd3
  } reason_e;

  typedef struct packed {
    logic sampleLock;
    logic loadCtl;
    logic evalReq;
  } strobe_t;

endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctlWrEn,
  input  logic    reqValid,
  input  op_e     reqOp,
  output strobe_t stb
);

  logic ready;

  always_ff @(posedge clk) begin
    if (!rstN) ready <= 1'b0;
    else       ready <= 1'b1;
  end

  always_comb begin
    stb.sampleLock = !ready;
    stb.loadCtl    = ctlWrEn;
    stb.evalReq    = ready && reqValid && (reqOp != OP_RSVD);
  end

  AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.sampleLock |=> !stb.sampleLock); // R1

  AST_NO_EVAL_DURING_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.sampleLock && stb.evalReq)); // R1

endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int USER_KB    = 8,
  parameter int PAGE_BYTES = 512,
  localparam int USER_BYTES = USER_KB * 1024,
  localparam int ADDR_W     = $clog2(USER_BYTES),
  localparam int PG_SHIFT   = $clog2(PAGE_BYTES),
  localparam int NUM_PAGES  = USER_BYTES / PAGE_BYTES,
  localparam int LOCK_PAGE  = NUM_PAGES - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        lockByteIn,
  input  logic [1:0]        ctlWrData,
  input  op_e               reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDebug,
  input  logic [ADDR_W-1:0] execAddr,
  output logic              grant,
  output logic              violation,
  output reason_e           violCode
);

  logic [7:0]           lockByte;
  logic                 lockValid;
  logic                 wrEn, erEn;
  logic [7:0]           lockCount;
  logic [NUM_PAGES-1:0] lockedMask, tgtHit, execHit;
  logic                 tgtLocked, execLocked;
  reason_e              rsn;

  assign lockCount = ~lockByte;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    if (p == LOCK_PAGE) begin : g_lockpg
      assign lockedMask[p] = (lockCount != 8'd0);
    end else begin : g_userpg
      assign lockedMask[p] = (9'(p) < {1'b0, lockCount});
    end
    assign tgtHit[p]  = ((reqAddr  >> PG_SHIFT) == ADDR_W'(p));
    assign execHit[p] = ((execAddr >> PG_SHIFT) == ADDR_W'(p));
  end

  assign tgtLocked  = |(tgtHit  & lockedMask);
  assign execLocked = |(execHit & lockedMask);

  always_comb begin
    rsn = RSN_NONE;
    if (tgtLocked && (reqDebug || !execLocked))
      rsn = RSN_LOCKED;
    else if (!reqDebug && reqOp == OP_WRITE && !wrEn)
      rsn = RSN_WR_OFF;
    else if (!reqDebug && reqOp == OP_ERASE && !(wrEn && erEn))
      rsn = RSN_ER_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockByte  <= 8'hFF;
      lockValid <= 1'b0;
      wrEn      <= 1'b0;
      erEn      <= 1'b0;
      grant     <= 1'b0;
      violation <= 1'b0;
      violCode  <= RSN_NONE;
    end else begin
      if (stb.sampleLock) begin
        lockByte  <= lockByteIn;
        lockValid <= 1'b1;
      end
      if (stb.loadCtl) begin
        wrEn <= ctlWrData[0];
        erEn <= ctlWrData[1];
      end
      grant     <= stb.evalReq && (rsn == RSN_NONE);
      violation <= stb.evalReq && (rsn != RSN_NONE);
      violCode  <= stb.evalReq ? rsn : RSN_NONE;
    end
  end

  AST_NO_OUT_BEFORE_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !lockValid |=> !grant && !violation); // R1

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && violation)); // R10

  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !violation |-> violCode == RSN_NONE); // R10

  AST_DEBUG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalReq && reqDebug && tgtLocked) |=> violation && violCode == RSN_LOCKED); // R4

  AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalReq && !reqDebug && reqOp == OP_WRITE && !wrEn) |=> !grant); // R6

  AST_ERASE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalReq && !reqDebug && reqOp == OP_ERASE && !(wrEn && erEn)) |=> !grant); // R7

  AST_LOCKPAGE_RULE: assert property (@(posedge clk) disable iff (!rstN)
    lockValid |-> (lockedMask[LOCK_PAGE] == (lockByte != 8'hFF))); // R3

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int USER_KB    = 8,
  parameter int PAGE_BYTES = 512,
  localparam int USER_BYTES = USER_KB * 1024,
  localparam int ADDR_W     = $clog2(USER_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        lockByteIn,
  input  logic              ctlWrEn,
  input  logic [1:0]        ctlWrData,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDebug,
  input  logic [ADDR_W-1:0] execAddr,
  output logic [ADDR_W-1:0] lockAddr,
  output logic              grant,
  output logic              violation,
  output logic [1:0]        violCode
);

  strobe_t stb;
  reason_e code;
  op_e     opTyped;

  assign opTyped  = op_e'(reqOp);
  assign lockAddr = ADDR_W'(USER_BYTES - 1);
  assign violCode = code;

  flash_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrEn  (ctlWrEn),
    .reqValid (reqValid),
    .reqOp    (opTyped),
    .stb      (stb)
  );

  flash_guard_dp #(
    .USER_KB    (USER_KB),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .lockByteIn (lockByteIn),
    .ctlWrData  (ctlWrData),
    .reqOp      (opTyped),
    .reqAddr    (reqAddr),
    .reqDebug   (reqDebug),
    .execAddr   (execAddr),
    .grant      (grant),
    .violation  (violation),
    .violCode   (code)
  );

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;

  localparam int AW    = 13;
  localparam int LPAGE = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    lockByteIn = 8'hFF;
  logic          ctlWrEn = 1'b0;
  logic [1:0]    ctlWrData = 2'b00;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic          reqDebug = 1'b0;
  logic [AW-1:0] execAddr = '0;
  logic [AW-1:0] lockAddr;
  logic          grant, violation;
  logic [1:0]    violCode;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    doneFlag = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  flash_guard u_dut (
    .clk(clk), .rstN(rstN), .lockByteIn(lockByteIn), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqDebug(reqDebug), .execAddr(execAddr), .lockAddr(lockAddr),
    .grant(grant), .violation(violation), .violCode(violCode)
  );

  // behavioural reference model
  bit       mValid, mWe, mEe, mGrant, mViol;
  int       mCode;
  int       mLock;

  function automatic bit pageProt(int page, int lb);
    int n = 255 - lb;
    return (page < n && page != LPAGE) || (page == LPAGE && n > 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mValid <= 0; mWe <= 0; mEe <= 0; mGrant <= 0; mViol <= 0; mCode <= 0;
    end else begin
      int  c;
      bit  tLock, trusted;
      if (!mValid) begin mValid <= 1; mLock <= int'(lockByteIn); end
      if (ctlWrEn) begin mWe <= ctlWrData[0]; mEe <= ctlWrData[1]; end
      mGrant <= 0; mViol <= 0; mCode <= 0;
      if (mValid && reqValid && reqOp != 2'd3) begin
        tLock   = pageProt(int'(reqAddr) / 512, mLock);
        trusted = !reqDebug && pageProt(int'(execAddr) / 512, mLock);
        c = 0;
        if (tLock && !trusted) c = 3;
        else if (!reqDebug && reqOp == 2'd1 && !mWe) c = 1;
        else if (!reqDebug && reqOp == 2'd2 && !(mWe && mEe)) c = 2;
        mGrant <= (c == 0); mViol <= (c != 0); mCode <= c;
      end
    end
  end

  always @(negedge clk) begin
    if (!doneFlag) begin
      nChecks++;
      if (grant !== mGrant || violation !== mViol || int'(violCode) != mCode) begin
        nFails++;
        $display("FAIL %s model: got g=%0b v=%0b c=%0d expected g=%0b v=%0b c=%0d",
                 curReq, grant, violation, violCode, mGrant, mViol, mCode);
      end
    end
  end

  task automatic chk(bit g, bit v, int c, string tag);
    nChecks++;
    if (grant !== g || violation !== v || int'(violCode) != c) begin
      nFails++;
      $display("FAIL %s: got g=%0b v=%0b c=%0d expected g=%0b v=%0b c=%0d",
               tag, grant, violation, violCode, g, v, c);
    end
  endtask

  // drive at negedge, check response at the next negedge
  task automatic doReq(int op, int addr, bit dbg, int exec, bit g, bit v, int c, string tag);
    curReq   = tag;
    reqValid = 1; reqOp = 2'(op); reqAddr = AW'(addr); reqDebug = dbg; execAddr = AW'(exec);
    @(negedge clk);
    reqValid = 0;
    chk(g, v, c, tag);
  endtask

  task automatic setCtl(int d);
    ctlWrEn = 1; ctlWrData = 2'(d);
    @(negedge clk);
    ctlWrEn = 0;
  endtask

  task automatic doReset(int lb);
    curReq = "R1";
    rstN = 0; lockByteIn = 8'(lb);
    repeat (3) @(negedge clk);
    chk(0, 0, 0, "R1 in reset");
    rstN = 1;
  endtask

  initial begin
    @(negedge clk);
    doReset(8'hFB);
    nChecks++;
    if (lockAddr !== 13'h1FFF) begin
      nFails++; $display("FAIL R3 lockAddr: got %h expected 1fff", lockAddr);
    end
    // request on the capture cycle is ignored
    doReq(0, 'h0800, 1, 0, 0, 0, 0, "R1 early");
    lockByteIn = 8'hFF; // ignored after capture
    doReq(0, 'h0000, 1, 0, 0, 1, 3, "R2 page0");
    doReq(0, 'h0600, 1, 0, 0, 1, 3, "R2 page3");
    doReq(0, 'h0800, 1, 0, 1, 0, 0, "R2 page4");
    doReq(0, 'h1FFF, 1, 0, 0, 1, 3, "R3 lockpage");
    doReq(0, 'h0200, 0, 'h0A00, 0, 1, 3, "R4 unlocked code");
    doReq(2, 'h1E00, 1, 0, 0, 1, 3, "R4 debug erase");
    doReq(0, 'h1E00, 0, 'h0100, 1, 0, 0, "R5 trusted read lockpage");
    doReq(0, 'h0C00, 0, 'h0100, 1, 0, 0, "R5 trusted read free");
    doReq(1, 'h0C00, 0, 'h0A00, 0, 1, 1, "R6 write off");
    setCtl(1);
    doReq(1, 'h0C00, 0, 'h0A00, 1, 0, 0, "R11 write on");
    doReq(2, 'h0C00, 0, 'h0A00, 0, 1, 2, "R7 erase off");
    setCtl(3);
    doReq(2, 'h0C00, 0, 'h0A00, 1, 0, 0, "R7 erase on");
    doReq(1, 'h0400, 0, 'h0100, 1, 0, 0, "R5 trusted write prot");
    doReq(2, 'h1E00, 0, 'h0100, 1, 0, 0, "R5 trusted erase prot");
    setCtl(2);
    doReq(2, 'h0C00, 0, 'h0A00, 0, 1, 2, "R7 erase without write");
    setCtl(0);
    doReq(1, 'h0C00, 1, 0, 1, 0, 0, "R8 debug write");
    doReq(2, 'h0C00, 1, 0, 1, 0, 0, "R8 debug erase");
    doReq(1, 'h0000, 0, 'h0A00, 0, 1, 3, "R9 both fail");
    doReq(2, 'h0200, 0, 'h0800, 0, 1, 3, "R9 erase both fail");
    doReq(1, 'h0400, 0, 'h0100, 0, 1, 1, "R5 trusted write off");
    doReq(3, 'h0800, 1, 0, 0, 0, 0, "R12 reserved");
    doReq(3, 'h0000, 1, 0, 0, 0, 0, "R12 reserved locked");
    // back-to-back
    curReq = "R10";
    reqValid = 1; reqOp = 0; reqAddr = 'h0000; reqDebug = 1;
    @(negedge clk);
    chk(0, 1, 3, "R10 first");
    reqAddr = 'h0800;
    @(negedge clk);
    chk(1, 0, 0, "R10 second");
    reqValid = 0;
    @(negedge clk);
    chk(0, 0, 0, "R10 idle");
    // ctl write and request in same cycle: request sees old value
    curReq = "R11";
    ctlWrEn = 1; ctlWrData = 2'b01;
    reqValid = 1; reqOp = 1; reqAddr = 'h0C00; reqDebug = 0; execAddr = 'h0A00;
    @(negedge clk);
    ctlWrEn = 0; reqValid = 0;
    chk(0, 1, 1, "R11 same cycle");
    doReq(1, 'h0C00, 0, 'h0A00, 1, 0, 0, "R11 next cycle");

    doReset(8'hFF);
    @(negedge clk);
    doReq(0, 'h1E00, 0, 'h0A00, 1, 0, 0, "R3 ff lockpage open");
    doReq(0, 'h0000, 1, 0, 1, 0, 0, "R2 ff page0 open");
    doReq(1, 'h0C00, 0, 'h0A00, 0, 1, 1, "R11 reset clears enable");

    doReset(8'hFE);
    @(negedge clk);
    doReq(0, 'h0000, 1, 0, 0, 1, 3, "R2 fe page0");
    doReq(0, 'h0200, 1, 0, 1, 0, 0, "R2 fe page1");
    doReq(0, 'h1E00, 1, 0, 0, 1, 3, "R3 fe lockpage");

    doReset(8'h00);
    @(negedge clk);
    doReq(0, 'h1400, 1, 0, 0, 1, 3, "R2 00 page10");
    doReq(0, 'h1C00, 0, 'h0000, 1, 0, 0, "R5 00 trusted read");

    repeat (2) @(negedge clk);
    doneFlag = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!doneFlag) begin
      doneFlag = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule